// File: doc/BRIEF.md
# Signed-Digit Serial Coefficient Adder

This block adds a constant coefficient to an operand that streams in one digit per clock, most significant digit first. The operand uses radix-2 signed digits from {-1, 0, +1}. Each digit travels on two wires: a positive wire and a negative wire. The coefficient is a two's complement word of `W` bits. The block captures it with the first digit of each operand word and then shifts it out internally in step with the operand. Because the digit set is redundant, a carry can only move into the next more significant position. Each result digit therefore depends on at most two more input digits, and the add time does not grow with the word length.

Every input word has exactly `W` digits. Every result word has `W+1` digits in the same two-wire form. The first result digit is the transfer out of the top position. `out_start` marks that digit. The value of a result word is the sum of d_j·2^(W−j) for j = 0..W. This equals the operand value plus the coefficient.

Both streams use a valid/ready handshake. A digit moves when valid and ready are both high at a clock edge.
- On the input side, `in_ready` may depend on `out_ready` in the same cycle.
- `in_ready` drops for one cycle after the last digit of every word is accepted. In that cycle the block emits the extra output digit.
- On the output side, once `out_valid` is high, the digit and start flag stay unchanged until `out_ready` takes them.

Top module: `sd_serial_coef_adder`

## Requirements
- R1: The digit encoding on both streams is {pos,neg} = 10 for +1, 01 for −1 and 00 for 0. An input pair 11 is taken as 0, and no output digit is ever 11.
- R2: For each input word of `W` digits, the output carries exactly `W+1` digits, the first one flagged by `out_start`. The value of the output word is the operand value plus the coefficient read as two's complement.
- R3: The coefficient is sampled only in the cycle that accepts a start digit. Its value in any other cycle has no effect on the result.
- R4: When `out_ready` is held high and digits arrive without gaps, the flagged first output digit is valid two cycles after its word's start digit is accepted.
- R5: When input is always valid and output is always ready, a new word is accepted every `W+1` cycles. `in_ready` is low for exactly the one cycle after a word's last digit is accepted.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pos`, `out_neg` and `out_start` hold their values.
- R7: During and right after reset, `out_valid` is low and `in_ready` is high.
- R8: A start digit discards all transfer state left from the previous word. The result of each word is independent of the word before it, even when words are sent back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_in | input | W | Two's complement coefficient, sampled with the start digit |
| in_valid | input | 1 | Input digit is valid |
| in_ready | output | 1 | Block accepts an input digit this cycle |
| in_start | input | 1 | Input digit is the most significant digit of a word |
| in_pos | input | 1 | Positive wire of the input digit |
| in_neg | input | 1 | Negative wire of the input digit |
| out_valid | output | 1 | Output digit is valid |
| out_ready | input | 1 | Consumer takes the output digit this cycle |
| out_start | output | 1 | Output digit is the first (top) digit of a result word |
| out_pos | output | 1 | Positive wire of the output digit |
| out_neg | output | 1 | Negative wire of the output digit |

## Verification
The digit-range and bubble assertions assume well-framed input:
- Every word begins with a flagged digit and carries exactly `W` digits.
- A digit offered with `in_valid` stays on the pins until it is taken.

Under these conditions, the lookahead digit that the transfer logic sees always belongs to the same word, or is the implicit zero past its end. The stimulus only ever sends complete words in this form and holds each digit until the handshake completes. Its freedom lies elsewhere:
- It inserts idle cycles within and between words.
- It stalls the output at pseudo-random times.
- It drives a different coefficient on every non-start digit.

// File: rtl/sdca_pkg.sv
package sdca_pkg;

  // Two-wire signed digit: {1,0} = +1, {0,1} = -1, {0,0} and {1,1} = 0
  typedef struct packed {
    logic pos;
    logic neg;
  } sd_t;

  localparam sd_t SD_ZERO = '{pos: 1'b0, neg: 1'b0};

  function automatic logic signed [2:0] sd_value(sd_t d);
    if (d.pos && !d.neg)      return 3'sd1;
    else if (d.neg && !d.pos) return 3'sb111;
    else                      return 3'sd0;
  endfunction

  // Argument must lie in -1..+1; the both-ones code is never built
  function automatic sd_t sd_encode(logic signed [2:0] v);
    sd_t r;
    r.pos = (v == 3'sd1);
    r.neg = (v == 3'sb111);
    return r;
  endfunction

  function automatic logic sd_nonneg(sd_t d);
    return !(d.neg && !d.pos);
  endfunction

endpackage

// File: rtl/sdca_transfer.sv
// Splits the position sum of one operand digit and one coefficient digit
// into a transfer digit (to the next more significant position) and an
// interim digit, chosen by looking at the sign of the next lower position.
module sdca_transfer
  import sdca_pkg::*;
(
  input  sd_t  x_dig,
  input  sd_t  y_dig,
  input  logic la_nonneg,
  output sd_t  t_dig,
  output sd_t  w_dig
);

  logic signed [2:0] psum;

  always_comb begin
    psum  = sd_value(x_dig) + sd_value(y_dig);
    t_dig = SD_ZERO;
    w_dig = SD_ZERO;
    case (psum)
      3'sd2:   t_dig.pos = 1'b1;
      3'sb110: t_dig.neg = 1'b1;
      3'sd1: begin
        if (la_nonneg) begin
          t_dig.pos = 1'b1;
          w_dig.neg = 1'b1;
        end else begin
          w_dig.pos = 1'b1;
        end
      end
      3'sb111: begin
        if (la_nonneg) begin
          w_dig.neg = 1'b1;
        end else begin
          t_dig.neg = 1'b1;
          w_dig.pos = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdca_coef_seq.sv
// Captures the coefficient with the start digit and presents, for the digit
// now on the input, the matching coefficient digit (sign bit -> -1) and
// whether that digit is the last of its word.
module sdca_coef_seq
  import sdca_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] coef_in,
  input  logic         cur_start,
  input  logic         take,
  output sd_t          y_dig,
  output logic         y_last
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  coef_q;
  logic [CW-1:0] cnt;

  always_comb begin
    y_dig.pos = cur_start ? 1'b0 : coef_q[W-1];
    y_dig.neg = cur_start ? coef_in[W-1] : 1'b0;
    y_last    = cur_start ? (W == 1) : (cnt == CW'(W - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coef_q <= '0;
      cnt    <= CW'(W);
    end else if (take) begin
      if (cur_start) begin
        coef_q <= coef_in << 1;
        cnt    <= CW'(1);
      end else begin
        coef_q <= coef_q << 1;
        if (cnt != CW'(W)) cnt <= cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/sdca_out_stage.sv
// Output digit register with a valid/ready hold.
module sdca_out_stage
  import sdca_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  sd_t  d,
  input  logic d_start,
  input  logic out_ready,
  output logic out_valid,
  output logic out_pos,
  output logic out_neg,
  output logic out_start,
  output logic free
);

  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pos   <= 1'b0;
      out_neg   <= 1'b0;
      out_start <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_pos   <= d.pos;
      out_neg   <= d.neg;
      out_start <= d_start;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_pos) && $stable(out_neg) && $stable(out_start)));

  p_no_both_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_pos && out_neg));

endmodule

// File: rtl/sd_serial_coef_adder.sv
// Online signed-digit adder: serial operand plus stored coefficient,
// most significant digit first, fixed two-digit delay.
module sd_serial_coef_adder
  import sdca_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] coef_in,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_start,
  input  logic         in_pos,
  input  logic         in_neg,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         out_start,
  output logic         out_pos,
  output logic         out_neg
);

  // Holding stage: one digit waiting for its lookahead, or the end-of-word
  // marker that releases the final interim digit.
  logic a_valid, a_flush, a_start, a_last;
  sd_t  a_x, a_y;
  sd_t  b_w;              // interim digit of the position above the held one

  sd_t  in_dig, y_dig, t_dig, w_dig, s_dig;
  logic y_last, o_free, la_nonneg, emit, accept;
  logic signed [2:0] s_val;

  assign in_dig = '{pos: in_pos, neg: in_neg};

  sdca_coef_seq #(.W(W)) u_coef (
    .clk      (clk),
    .rst_n    (rst_n),
    .coef_in  (coef_in),
    .cur_start(in_start),
    .take     (accept),
    .y_dig    (y_dig),
    .y_last   (y_last)
  );

  always_comb begin
    if (a_last && !a_flush) la_nonneg = 1'b1;   // beyond the last digit: zero
    else la_nonneg = in_start || (sd_nonneg(in_dig) && sd_nonneg(y_dig));
  end

  sdca_transfer u_xfer (
    .x_dig    (a_x),
    .y_dig    (a_y),
    .la_nonneg(la_nonneg),
    .t_dig    (t_dig),
    .w_dig    (w_dig)
  );

  assign in_ready = !a_valid || (o_free && (a_flush || !a_last));
  assign accept   = in_valid && in_ready;
  assign emit     = a_valid && o_free && (a_flush || a_last || in_valid);

  always_comb begin
    if (a_flush)      s_val = sd_value(b_w);
    else if (a_start) s_val = sd_value(t_dig);
    else              s_val = sd_value(b_w) + sd_value(t_dig);
    s_dig = sd_encode(s_val);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_valid <= 1'b0;
      a_flush <= 1'b0;
      a_start <= 1'b0;
      a_last  <= 1'b0;
      a_x     <= SD_ZERO;
      a_y     <= SD_ZERO;
      b_w     <= SD_ZERO;
    end else begin
      if (emit && !a_flush) b_w <= w_dig;
      if (accept) begin
        a_valid <= 1'b1;
        a_flush <= 1'b0;
        a_x     <= in_dig;
        a_y     <= y_dig;
        a_start <= in_start;
        a_last  <= y_last;
      end else if (emit) begin
        if (!a_flush && a_last) begin
          a_flush <= 1'b1;
        end else begin
          a_valid <= 1'b0;
          a_flush <= 1'b0;
        end
      end
    end
  end

  sdca_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (emit),
    .d        (s_dig),
    .d_start  (a_start && !a_flush),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_pos  (out_pos),
    .out_neg  (out_neg),
    .out_start(out_start),
    .free     (o_free)
  );

  // Interim digit plus incoming transfer must stay inside the digit set
  p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (s_val <= 3'sd1 && s_val >= 3'sb111));

  // One input bubble follows each accepted last digit
  p_bubble_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && y_last) |=> !in_ready);

  // Nothing is emitted before a digit has been held
  p_emit_needs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_valid && !out_valid) |=> !out_valid);

endmodule

// File: tb/tb_sd_serial_coef_adder.sv
`timescale 1ns/1ps
module tb_sd_serial_coef_adder;

  localparam int W  = 4;
  localparam int NW = W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] coef_in = '0;
  logic in_valid = 1'b0, in_start = 1'b0, in_pos = 1'b0, in_neg = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_start, out_pos, out_neg;

  sd_serial_coef_adder #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .coef_in(coef_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_start(in_start),
    .in_pos(in_pos), .in_neg(in_neg),
    .out_valid(out_valid), .out_ready(out_ready), .out_start(out_start),
    .out_pos(out_pos), .out_neg(out_neg)
  );

  int errors = 0, checks = 0, cyc = 0;
  int exp_q[$];
  string tag_q[$];
  int start_cyc_q[$];
  logic lat_on = 1'b0, thr_on = 1'b0, stall_on = 1'b0;
  int last_start = -1;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp_v,
                       input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  // digit code: 0 -> 00, 1 -> +1 (10), 2 -> -1 (01), 3 -> both wires (reads 0)
  function automatic int dval(input int code);
    if (code == 1) return 1;
    if (code == 2) return -1;
    return 0;
  endfunction

  // output stall pattern
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = stall_on ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  task automatic send_word(input int codes[W], input int coef, input string tag,
                           input bit gaps);
    int expv;
    logic acc;
    expv = coef;
    for (int i = 0; i < W; i++) expv += dval(codes[i]) * (1 << (W - 1 - i));
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    for (int i = 0; i < W; i++) begin
      if (gaps && lfsr[2]) begin
        in_valid = 1'b0;
        @(posedge clk); #2;
      end
      in_valid = 1'b1;
      in_start = (i == 0);
      in_pos   = (codes[i] == 1 || codes[i] == 3);
      in_neg   = (codes[i] == 2 || codes[i] == 3);
      // R3: coefficient pins carry unrelated values on non-start digits
      coef_in  = (i == 0) ? W'(coef) : W'(coef ^ (5 + 3 * i));
      do begin
        @(negedge clk);
        acc = in_ready;
        @(posedge clk); #2;
      end while (!acc);
    end
    in_valid = 1'b0;
    in_start = 1'b0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 3000) begin
      @(posedge clk); #2;
      t++;
    end
    repeat (4) @(posedge clk);
    #2;
    check(exp_q.size() == 0, "R2", exp_q.size(), 0, "words never completed");
  endtask

  // monitor
  int acc_v = 0, nd = 0, mon_dv = 0, mon_e = 0, mon_s = 0;
  logic collecting = 1'b0, prev_stall = 1'b0;
  logic [2:0] prev_o = '0;
  string mon_t;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && ({out_pos, out_neg, out_start} == prev_o), "R6",
              {out_valid, out_pos, out_neg, out_start}, {1'b1, prev_o}, "held output");
      prev_stall = out_valid && !out_ready;
      prev_o     = {out_pos, out_neg, out_start};

      if (in_valid && in_ready && in_start) begin
        if (lat_on) start_cyc_q.push_back(cyc);
        if (thr_on && last_start >= 0)
          check(cyc - last_start == NW, "R5", cyc - last_start, NW, "start spacing");
        last_start = thr_on ? cyc : -1;
      end

      if (out_valid && out_ready) begin
        check(!(out_pos && out_neg), "R1", {out_pos, out_neg}, 0, "both wires set");
        mon_dv = (out_pos && !out_neg) ? 1 : ((out_neg && !out_pos) ? -1 : 0);
        if (out_start) begin
          if (collecting) check(1'b0, "R2", nd, NW, "word cut short");
          collecting = 1'b1;
          acc_v = 0;
          nd = 0;
          if (lat_on) begin
            if (start_cyc_q.size() == 0) check(1'b0, "R4", 0, 1, "start without input");
            else begin
              mon_s = start_cyc_q.pop_front();
              check(cyc - mon_s == 2, "R4", cyc - mon_s, 2, "start latency");
            end
          end
        end
        if (collecting) begin
          acc_v = acc_v * 2 + mon_dv;
          nd++;
          if (nd == NW) begin
            collecting = 1'b0;
            if (exp_q.size() == 0) check(1'b0, "R2", acc_v, 0, "unexpected word");
            else begin
              mon_e = exp_q.pop_front();
              mon_t = tag_q.pop_front();
              check(acc_v == mon_e, mon_t, acc_v, mon_e, "word value");
            end
          end
        end else begin
          check(1'b0, "R2", mon_dv, 0, "digit outside a word");
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cd[W];
    int coefs[5] = '{-8, -3, 0, 5, 7};
    int v;
    bit has3;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R7", out_valid, 0, "out_valid in reset");
    check(in_ready, "R7", in_ready, 1, "in_ready in reset");
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R7", out_valid, 0, "out_valid after reset");
    check(in_ready, "R7", in_ready, 1, "in_ready after reset");
    @(posedge clk); #2;

    // Phase 1: every operand over {-1,0,+1}^W with every coefficient, back to back
    lat_on = 1'b1;
    thr_on = 1'b1;
    for (int c = -(1 << (W - 1)); c < (1 << (W - 1)); c++) begin
      for (int op = 0; op < 81; op++) begin
        v = op;
        for (int i = 0; i < W; i++) begin
          cd[i] = v % 3;
          v = v / 3;
        end
        send_word(cd, c, "R2", 1'b0);
      end
    end
    drain();
    lat_on = 1'b0;
    thr_on = 1'b0;

    // Phase 2: all four wire codes including 11, with gaps and output stalls
    stall_on = 1'b1;
    for (int k = 0; k < 5; k++) begin
      for (int op = 0; op < 256; op++) begin
        has3 = 1'b0;
        for (int i = 0; i < W; i++) begin
          cd[i] = (op >> (2 * i)) & 3;
          if (cd[i] == 3) has3 = 1'b1;
        end
        send_word(cd, coefs[k], has3 ? "R1" : "R6", 1'b1);
      end
    end
    drain();
    stall_on = 1'b0;

    // Phase 3: state left by extreme words must not reach the next word (R8)
    for (int i = 0; i < W; i++) cd[i] = 1;
    send_word(cd, 7, "R2", 1'b0);
    for (int i = 0; i < W; i++) cd[i] = 0;
    send_word(cd, 0, "R8", 1'b0);
    for (int i = 0; i < W; i++) cd[i] = 2;
    send_word(cd, -8, "R2", 1'b0);
    for (int i = 0; i < W; i++) cd[i] = 0;
    send_word(cd, -1, "R8", 1'b0);
    send_word(cd, 3, "R3", 1'b0);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule